// File: doc/BRIEF.md
# 64-Source Level Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines into one processor interrupt. Each source has a pending flag, which a high input sets and which holds until software clears it, and an enable bit that decides whether the flag is reported. Software reads the enabled pending sources as two 32-bit status words. It acknowledges a source by writing a one to that source's bit in a byte-indexed clear area.

A routing byte steers the combined request to either a regular interrupt pin or a fast interrupt pin. Both pins are registered. The register port is a plain memory-mapped bus with a byte address and four byte enables. Reads are combinational while a read is selected, and writes take effect at the clock edge.

Top module: `irq_hub64`

## Requirements
- R1: A source's flag is set at any clock edge where its input line is high, whether or not the source is enabled.
- R2: If a line is still high at the edge where its flag is cleared, the flag stays set, because a set beats a clear in the same cycle.
- R3: Once set, a flag holds after its line returns low and is removed only by a clear write.
- R4: Writing a byte to offset 0x40+n (n = 0..7, little-endian lanes) clears the flag of source 8n+b for each bit b written as 1. Bits written as 0 leave their flags unchanged.
- R5: Enable bits sit in bytes 0x50..0x57. Byte n covers sources 8n..8n+7, and the word at 0x50 holds sources 0..31 and the word at 0x54 holds sources 32..63. They can be written as whole words or as single bytes, a byte write changes only its own byte, and they read back as written.
- R6: The status word at 0x58 (sources 0..31) and the word at 0x5C (sources 32..63) read as flag AND enable. Writing zero to both enable words makes both status words read zero and keeps both interrupt pins low. Writes to the status words are ignored.
- R7: The routing byte at offset 0x3A4 reads back as written. With value 1 the OR of all status bits drives irq_out. With value 0 it drives fiq_out. Any other value holds both pins low.
- R8: The pins are registered. A flag set at edge P shows on the selected pin after edge P+1 and not before.
- R9: After reset, all flags, all enables and the routing byte are zero, both pins are low, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 64 | Level-sensitive request lines, bit k is source k |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, bits 1:0 ignored for lane selection |
| bus_be | input | 4 | Byte enables, lane i = data bits 8i+7:8i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| irq_out | output | 1 | Regular interrupt pin |
| fiq_out | output | 1 | Fast interrupt pin |

## Verification
The capture path is driven with one-cycle pulses, to show that flags hold, and with lines held high across a clear, to show that a set beats a clear. A line asserted while its source is disabled shows that capture and masking are separate. Clear bytes with mixed ones and zeros, together with byte-lane enable writes, separate exact bit targeting from whole-word effects. Routing values 1, 0 and 2 are each tried with the same pending source, and a single isolated request is timed edge by edge to pin the register stage of the outputs.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   // Byte offsets of the register areas.
   localparam int unsigned CLR_BASE   = 32'h040;
   localparam int unsigned EN_BASE    = 32'h050;
   localparam int unsigned ST_BASE    = 32'h058;
   localparam int unsigned ROUTE_ADDR = 32'h3A4;
   localparam int unsigned LANES      = 4;

   localparam logic [7:0] ROUTE_FAST = 8'd0;
   localparam logic [7:0] ROUTE_REG  = 8'd1;
endpackage

// File: rtl/irq_hub_flags.sv
module irq_hub_flags #(
   parameter int unsigned N_SRC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] lines,
   input  logic [N_SRC-1:0] clr,
   output logic [N_SRC-1:0] flags
);
   for (genvar k = 0; k < N_SRC; k++) begin : g_src
      logic f_q;
      // set has priority over clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) f_q <= 1'b0;
         else        f_q <= lines[k] | (f_q & ~clr[k]);
      end
      assign flags[k] = f_q;
   end
endmodule

// File: rtl/irq_hub_regif.sv
module irq_hub_regif
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC  = 64,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   input  logic [N_SRC-1:0]  status,
   output logic [N_SRC-1:0]  en_q,
   output logic [N_SRC-1:0]  clr_vec,
   output logic [7:0]        route_q,
   output logic [31:0]       bus_rdata
);
   localparam int unsigned NB = N_SRC / 8;
   localparam int unsigned WA = ADDR_W - 2;
   localparam int unsigned RL = ROUTE_ADDR % LANES;
   localparam logic [WA-1:0] RW = WA'(ROUTE_ADDR / LANES);

   logic [WA-1:0] word_a;
   logic          wr_fire, rd_fire;
   logic [1:0]    unused_lo;
   logic [31:0]   en_part [NB];
   logic [31:0]   st_part [NB];
   logic [31:0]   rt_part;

   assign word_a    = bus_addr[ADDR_W-1:2];
   assign unused_lo = bus_addr[1:0];
   assign wr_fire   = bus_sel & bus_wr;
   assign rd_fire   = bus_sel & ~bus_wr;

   for (genvar n = 0; n < NB; n++) begin : g_byte
      localparam int unsigned EL = (EN_BASE + n) % LANES;
      localparam int unsigned SL = (ST_BASE + n) % LANES;
      localparam int unsigned CL = (CLR_BASE + n) % LANES;
      localparam logic [WA-1:0] EW = WA'((EN_BASE + n) / LANES);
      localparam logic [WA-1:0] SW = WA'((ST_BASE + n) / LANES);
      localparam logic [WA-1:0] CW = WA'((CLR_BASE + n) / LANES);

      logic [7:0] en_b;
      logic       en_wr, clr_wr;

      assign en_wr  = wr_fire && (word_a == EW) && bus_be[EL];
      assign clr_wr = wr_fire && (word_a == CW) && bus_be[CL];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     en_b <= '0;
         else if (en_wr) en_b <= bus_wdata[8*EL +: 8];
      end

      assign en_q[8*n +: 8]    = en_b;
      assign clr_vec[8*n +: 8] = clr_wr ? bus_wdata[8*CL +: 8] : 8'h00;
      assign en_part[n] = (rd_fire && word_a == EW) ? (32'(en_b) << (8*EL)) : 32'h0;
      assign st_part[n] = (rd_fire && word_a == SW) ? (32'(status[8*n +: 8]) << (8*SL)) : 32'h0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   route_q <= '0;
      else if (wr_fire && word_a == RW && bus_be[RL]) route_q <= bus_wdata[8*RL +: 8];
   end

   assign rt_part = (rd_fire && word_a == RW) ? (32'(route_q) << (8*RL)) : 32'h0;

   always_comb begin
      bus_rdata = rt_part;
      for (int n = 0; n < NB; n++) bus_rdata = bus_rdata | en_part[n] | st_part[n];
   end
endmodule

// File: rtl/irq_hub_out.sv
module irq_hub_out
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC   = 64,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] status,
   input  logic [7:0]       route,
   output logic             irq_out,
   output logic             fiq_out
);
   logic any, irq_d, fiq_d;
   assign any   = |status;
   assign irq_d = any && (route == ROUTE_REG);
   assign fiq_d = any && (route == ROUTE_FAST);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_out <= 1'b0;
            fiq_out <= 1'b0;
         end else begin
            irq_out <= irq_d;
            fiq_out <= fiq_d;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_out = irq_d;
      assign fiq_out = fiq_d;
   end
endmodule

// File: rtl/irq_hub64.sv
module irq_hub64
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC   = 64,
   parameter int unsigned ADDR_W  = 12,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_lines,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_out,
   output logic              fiq_out
);
   if (N_SRC % 8 != 0 || N_SRC == 0 || N_SRC > 64) begin : g_bad_src
      $error("N_SRC must be a non-zero multiple of 8 not above 64");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W too narrow for the routing byte");
   end

   logic [N_SRC-1:0] flag_q, en_q, clr_vec, status_w;
   logic [7:0]       route_q;

   assign status_w = flag_q & en_q;

   irq_hub_flags #(.N_SRC(N_SRC)) i_flags (
      .clk(clk), .rst_n(rst_n), .lines(irq_lines), .clr(clr_vec), .flags(flag_q)
   );

   irq_hub_regif #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) i_regif (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .status(status_w), .en_q(en_q), .clr_vec(clr_vec), .route_q(route_q),
      .bus_rdata(bus_rdata)
   );

   irq_hub_out #(.N_SRC(N_SRC), .REG_OUT(REG_OUT)) i_out (
      .clk(clk), .rst_n(rst_n), .status(status_w), .route(route_q),
      .irq_out(irq_out), .fiq_out(fiq_out)
   );
endmodule

// File: rtl/irq_hub64_chk.sv
module irq_hub64_chk #(
   parameter int unsigned N_SRC = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [N_SRC-1:0] irq_lines,
   input logic [N_SRC-1:0] flags,
   input logic [N_SRC-1:0] status,
   input logic [N_SRC-1:0] en,
   input logic [7:0]       route,
   input logic             irq_out,
   input logic             fiq_out
);
   // R1, R2: every high line leaves its flag set after the edge
   assert_line_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lines != '0) |=> ((flags & $past(irq_lines)) == $past(irq_lines)));

   // R3: without a bus write no flag falls
   assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> ((flags & $past(flags)) == $past(flags)));

   // R6: all disabled keeps both pins low next cycle
   assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> (!irq_out && !fiq_out));

   // R7: regular channel
   assert_regular_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (route == 8'd1 && status != '0) |=> irq_out);

   // R7: fast channel
   assert_fast_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (route == 8'd0 && status != '0) |=> fiq_out);

   // R7: never both pins
   assert_one_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_out && fiq_out));
endmodule

bind irq_hub64 irq_hub64_chk #(.N_SRC(N_SRC)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .irq_lines(irq_lines), .flags(flag_q), .status(status_w), .en(en_q),
   .route(route_q), .irq_out(irq_out), .fiq_out(fiq_out)
);

// File: tb/test_irq_hub64.sv
module test_irq_hub64;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_lines = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out, fiq_out;

   int n_run = 0, n_fail = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } exp_t;
   exp_t sbq[$];

   always #5 clk = ~clk;

   irq_hub64 i_irq_hub64 (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out), .fiq_out(fiq_out)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data during every read cycle
   always begin
      @(negedge clk);
      #4;
      if (bus_sel && !bus_wr) begin
         if (sbq.size() == 0) chk(bus_rdata, 32'hx, "scoreboard empty");
         else begin
            exp_t e;
            e = sbq.pop_front();
            chk(bus_rdata, e.exp, e.tag);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      exp_t e;
      e.exp = exp; e.tag = tag;
      sbq.push_back(e);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'hF;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pins(input logic ei, input logic ef, input string tag);
      chk({31'b0, irq_out}, {31'b0, ei}, {tag, " irq_out"});
      chk({31'b0, fiq_out}, {31'b0, ef}, {tag, " fiq_out"});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      rd(12'h050, 32'h0, "R9 enable lo after reset");
      rd(12'h054, 32'h0, "R9 enable hi after reset");
      rd(12'h058, 32'h0, "R9 status lo after reset");
      rd(12'h05C, 32'h0, "R9 status hi after reset");
      rd(12'h3A4, 32'h0, "R9 route after reset");
      rd(12'h100, 32'h0, "R9 unmapped read");
      pins(1'b0, 1'b0, "R9 reset");

      // R7 route to regular channel
      wr(12'h3A4, 4'b0001, 32'h0000_0001);
      rd(12'h3A4, 32'h1, "R7 route readback");
      // R5 word write
      wr(12'h050, 4'hF, 32'hFFFF_FFFF);
      rd(12'h050, 32'hFFFF_FFFF, "R5 enable word readback");

      // R3 one-cycle pulse on source 5
      @(negedge clk); irq_lines[5] = 1'b1;
      @(negedge clk); irq_lines[5] = 1'b0;
      rd(12'h058, 32'h0000_0020, "R3 flag held after pulse");
      pins(1'b1, 1'b0, "R7 regular pin");

      // R1 capture while disabled, R5 byte enable write
      @(negedge clk); irq_lines[40] = 1'b1;
      @(negedge clk); irq_lines[40] = 1'b0;
      rd(12'h05C, 32'h0, "R6 disabled source hidden");
      wr(12'h054, 4'b0010, 32'h0000_FF00);
      rd(12'h054, 32'h0000_FF00, "R5 byte enable write");
      rd(12'h050, 32'hFFFF_FFFF, "R5 other word untouched");
      rd(12'h05C, 32'h0000_0100, "R1 flag captured while disabled");

      // R4 clear
      wr(12'h040, 4'b0001, 32'h0000_0020);
      rd(12'h058, 32'h0, "R4 clear source 5");
      wr(12'h044, 4'b0010, 32'h0000_FE00);
      rd(12'h05C, 32'h0000_0100, "R4 zero bit leaves source 40");
      wr(12'h044, 4'b0010, 32'h0000_0100);
      rd(12'h05C, 32'h0, "R4 clear source 40");

      // R2 set beats clear while line held
      wr(12'h054, 4'hF, 32'hFFFF_FFFF);
      @(negedge clk); irq_lines[63] = 1'b1;
      rd(12'h05C, 32'h8000_0000, "R2 source 63 pending");
      wr(12'h044, 4'b1000, 32'h8000_0000);
      rd(12'h05C, 32'h8000_0000, "R2 flag re-set while line high");
      irq_lines[63] = 1'b0;
      wr(12'h044, 4'b1000, 32'h8000_0000);
      rd(12'h05C, 32'h0, "R2 cleared after line low");

      // R6 status write ignored, disable all
      @(negedge clk); irq_lines[3] = 1'b1; irq_lines[35] = 1'b1;
      wr(12'h058, 4'hF, 32'hFFFF_FFFF);
      rd(12'h058, 32'h0000_0008, "R6 status write ignored");
      wr(12'h050, 4'hF, 32'h0);
      wr(12'h054, 4'hF, 32'h0);
      rd(12'h058, 32'h0, "R6 status lo after disable");
      rd(12'h05C, 32'h0, "R6 status hi after disable");
      pins(1'b0, 1'b0, "R6 disabled");

      // R7 fast channel and other value
      wr(12'h050, 4'hF, 32'hFFFF_FFFF);
      wr(12'h3A4, 4'b0001, 32'h0);
      @(negedge clk);
      pins(1'b0, 1'b1, "R7 fast route");
      wr(12'h3A4, 4'b0001, 32'h2);
      @(negedge clk);
      pins(1'b0, 1'b0, "R7 route value 2");
      rd(12'h3A4, 32'h2, "R7 route readback 2");

      // clean up, then R8 timing
      irq_lines = '0;
      wr(12'h040, 4'hF, 32'hFFFF_FFFF);
      wr(12'h044, 4'hF, 32'hFFFF_FFFF);
      rd(12'h058, 32'h0, "R4 word clear all");
      wr(12'h3A4, 4'b0001, 32'h1);
      @(negedge clk);
      pins(1'b0, 1'b0, "R8 idle");
      irq_lines[7] = 1'b1;
      @(negedge clk);
      irq_lines[7] = 1'b0;
      pins(1'b0, 1'b0, "R8 one edge after line");
      @(negedge clk);
      pins(1'b1, 1'b0, "R8 two edges after line");

      repeat (3) @(negedge clk);
      chk(32'(sbq.size()), 32'h0, "scoreboard drained");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule